// File: doc/BRIEF.md
# Single-Bank GPIO Controller with Atomic Set/Clear Aliases

This block controls one bank of general-purpose pins through a 32-bit register port with a single-cycle write strobe and a combinational read path. It holds an output latch, a per-pin direction register, and separate per-pin rising-edge and falling-edge enables. Software can update any of these one bit at a time with no read-modify-write sequence. Each control register has a write-one-to-set alias address and a write-one-to-clear alias address, and a write of zeros to either alias changes nothing.

The inputs pass through a two-flop synchroniser. The synchronised value can be read back as the pin level. It also feeds an edge detector, which records enabled transitions in a sticky status register. Software clears status bits by writing ones to them. A mask register chooses which status bits drive one combined interrupt output, and the mask leaves the status bits themselves unchanged. A system with more pins uses several identical banks. Pin n then sits in bank n/32, at bit n%32.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin is an input (`pin_oe`=0), `pin_out`=0, both edge-enable registers read 0, the edge status reads 0 and `irq` is 0.
- R2: A write to the output-set alias (offset 0x18) sets each output-latch bit whose write bit is 1 and leaves every other latch bit unchanged. `pin_out` reflects the latch after the write edge.
- R3: A write to the output-clear alias (offset 0x24) clears each output-latch bit whose write bit is 1 and leaves every other latch bit unchanged.
- R4: The direction register (offset 0x0C, 1 = output, driven on `pin_oe`) can be written directly. Writing ones to offset 0x54 sets the matching bits, and writing ones to offset 0x60 clears them.
- R5: The pin-level register (offset 0x00) returns the pin inputs after two clock edges of synchronisation. After one edge it still returns the previous value.
- R6: The rising-enable register (0x30) has set alias 0x6C and clear alias 0x78. The falling-enable register (0x3C) has set alias 0x84 and clear alias 0x90. Both enable registers can also be written directly.
- R7: A synchronised 0-to-1 transition on a pin whose rising enable is 1 sets that pin's bit in the edge status (0x48). A rising transition on a pin whose rising enable is 0 does not set the bit.
- R8: A synchronised 1-to-0 transition on a pin whose falling enable is 1 sets its status bit. A falling transition on a pin whose falling enable is 0 does not set the bit.
- R9: Writing to the edge status clears each bit written as 1 and leaves bits written as 0 unchanged.
- R10: If a new enabled edge on a pin arrives in the same cycle as a clear of that pin's status bit, the bit stays set.
- R11: `irq` is 1 exactly when some status bit is set and its bit in the edge mask (0x9C) is 1. Writing the mask never changes the status bits.
- R12: Registers sit every 12 bytes from 0x00 to 0x9C. The write-only aliases (0x18, 0x24, 0x54, 0x60, 0x6C, 0x78, 0x84, 0x90) and every other address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for `addr`, combinational |
| pin_in | input | WIDTH | Asynchronous pin inputs |
| pin_out | output | WIDTH | Output latch |
| pin_oe | output | WIDTH | Output enable per pin (direction) |
| irq | output | 1 | Masked OR of the edge status |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as a fresh enabled edge on that pin. The status bit must already be set, and the new edge must reach the detector through two synchroniser flops and the delay register. The bench first leaves the pin's status bit set and drops the pin without enabling falling detection. It then raises the pin at a known falling clock edge, idles exactly one cycle, and issues the write-one-to-clear so that it is sampled on the third rising edge, the same edge on which the detector fires. A second, ordinary clear then shows that the bit does respond to clears in other cycles.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_OSET  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_OCLR  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(8'h3C);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] A_DSET  = ADDR_W'(8'h54);
  localparam logic [ADDR_W-1:0] A_DCLR  = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] A_RSET  = ADDR_W'(8'h6C);
  localparam logic [ADDR_W-1:0] A_RCLR  = ADDR_W'(8'h78);
  localparam logic [ADDR_W-1:0] A_FSET  = ADDR_W'(8'h84);
  localparam logic [ADDR_W-1:0] A_FCLR  = ADDR_W'(8'h90);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(8'h9C);

  logic [WIDTH-1:0] out_q, dir_q, rise_q, fall_q, stat_q, mask_q;
  logic [WIDTH-1:0] sync1, sync2, prev;
  logic [WIDTH-1:0] ev;

  function automatic logic [WIDTH-1:0] upd(
    input logic [WIDTH-1:0] cur, input logic [WIDTH-1:0] d,
    input logic wr_full, input logic wr_set, input logic wr_clr);
    logic [WIDTH-1:0] r;
    r = cur;
    if (wr_full) r = d;
    if (wr_set)  r = r | d;
    if (wr_clr)  r = r & ~d;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign ev = (sync2 & ~prev & rise_q) | (~sync2 & prev & fall_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      out_q  <= upd(out_q,  wdata, 1'b0, wr_en && addr == A_OSET, wr_en && addr == A_OCLR);
      dir_q  <= upd(dir_q,  wdata, wr_en && addr == A_DIR,  wr_en && addr == A_DSET, wr_en && addr == A_DCLR);
      rise_q <= upd(rise_q, wdata, wr_en && addr == A_RISE, wr_en && addr == A_RSET, wr_en && addr == A_RCLR);
      fall_q <= upd(fall_q, wdata, wr_en && addr == A_FALL, wr_en && addr == A_FSET, wr_en && addr == A_FCLR);
      mask_q <= upd(mask_q, wdata, wr_en && addr == A_MASK, 1'b0, 1'b0);
      stat_q <= upd(stat_q, wdata, 1'b0, 1'b0, wr_en && addr == A_STAT) | ev;
    end
  end

  always_comb begin
    case (addr)
      A_LEVEL: rdata = sync2;
      A_DIR:   rdata = dir_q;
      A_RISE:  rdata = rise_q;
      A_FALL:  rdata = fall_q;
      A_STAT:  rdata = stat_q;
      A_MASK:  rdata = mask_q;
      default: rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(stat_q & mask_q);

  p_oset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_OSET) |=> ((pin_out & $past(wdata)) == $past(wdata)));
  p_oclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_OCLR) |=> ((pin_out & $past(wdata)) == '0));
  p_dset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DSET) |=> ((pin_oe & $past(wdata)) == $past(wdata)));
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ev)) == '0));
  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((stat_q & $past(ev)) == $past(ev)));
  p_mask_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK) |=> (stat_q == ($past(stat_q) | $past(ev))));
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pin_out, pin_oe, pin_in;
  logic [31:0] ext = '0;
  logic        irq;

  always #10 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_bank dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                   .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ext(input logic [31:0] v);
    @(negedge clk); ext = v;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // kind 0: rdata at address a, 1: irq, 2: pin_out, 3: pin_oe
  task automatic expect_item(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = rdata;
          1: act = {31'b0, irq};
          2: act = pin_out;
          default: act = pin_oe;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    // R1 reset state
    expect_item(0, 8'h0C, 32'h0, "R1 dir");
    expect_item(0, 8'h30, 32'h0, "R1 rise");
    expect_item(0, 8'h3C, 32'h0, "R1 fall");
    expect_item(0, 8'h48, 32'h0, "R1 status");
    expect_item(3, 8'h00, 32'h0, "R1 pin_oe");
    expect_item(2, 8'h00, 32'h0, "R1 pin_out");
    expect_item(1, 8'h00, 32'h0, "R1 irq");
    // R5 synchroniser latency
    set_ext(32'hA5A5_0F0F);
    idle(3);
    expect_item(0, 8'h00, 32'hA5A5_0F0F, "R5 level");
    set_ext(32'h0000_FFFF);
    expect_item(0, 8'h00, 32'hA5A5_0F0F, "R5 level after one edge");
    expect_item(0, 8'h00, 32'h0000_FFFF, "R5 level after two edges");
    // R12 aliases and holes read zero
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF);
    expect_item(0, 8'h18, 32'h0, "R12 oset alias");
    expect_item(0, 8'h54, 32'h0, "R12 dset alias");
    expect_item(0, 8'h04, 32'h0, "R12 unused 0x04");
    expect_item(0, 8'hA8, 32'h0, "R12 unused 0xA8");
    expect_item(0, 8'h9C, 32'h0, "R12 mask reset");
    // R4 direction
    wr(8'h0C, 32'h0000_00FF);
    expect_item(0, 8'h0C, 32'h0000_00FF, "R4 dir direct");
    wr(8'h54, 32'h0000_FF00);
    expect_item(0, 8'h0C, 32'h0000_FFFF, "R4 dir set");
    wr(8'h60, 32'h0000_000F);
    expect_item(0, 8'h0C, 32'h0000_FFF0, "R4 dir clear");
    expect_item(3, 8'h00, 32'h0000_FFF0, "R4 pin_oe");
    // R2 / R3 output latch
    wr(8'h18, 32'h0000_0030);
    expect_item(2, 8'h00, 32'h0000_0030, "R2 oset");
    wr(8'h18, 32'h0000_0100);
    expect_item(2, 8'h00, 32'h0000_0130, "R2 oset keeps others");
    wr(8'h24, 32'h0000_0010);
    expect_item(2, 8'h00, 32'h0000_0120, "R3 oclr");
    idle(3);
    expect_item(0, 8'h00, 32'h0000_012F, "R5 level with outputs");
    // back to inputs, quiet pins
    wr(8'h0C, 32'h0);
    set_ext(32'h0);
    idle(4);
    // R6 enables
    wr(8'h30, 32'h0000_000F);
    wr(8'h6C, 32'h0000_0100);
    wr(8'h78, 32'h0000_0001);
    expect_item(0, 8'h30, 32'h0000_010E, "R6 rise set/clear");
    wr(8'h84, 32'hF000_0000);
    expect_item(0, 8'h3C, 32'hF000_0000, "R6 fall set");
    wr(8'h90, 32'h1000_0000);
    expect_item(0, 8'h3C, 32'hE000_0000, "R6 fall clear");
    wr(8'h3C, 32'h0000_00F0);
    expect_item(0, 8'h3C, 32'h0000_00F0, "R6 fall direct");
    expect_item(0, 8'h48, 32'h0, "R6 no status yet");
    // R7 rising edges
    set_ext(32'h0000_0306);
    idle(4);
    expect_item(0, 8'h48, 32'h0000_0106, "R7 rising enabled only");
    // R8 falling edges
    set_ext(32'h0000_03F6);
    idle(4);
    expect_item(0, 8'h48, 32'h0000_0106, "R8 rise on fall-only pins ignored");
    set_ext(32'h0000_03A6);
    idle(4);
    expect_item(0, 8'h48, 32'h0000_0156, "R8 falling enabled");
    expect_item(1, 8'h00, 32'h0, "R11 irq masked off");
    // R9 write-one-to-clear
    wr(8'h48, 32'h0000_0004);
    expect_item(0, 8'h48, 32'h0000_0152, "R9 w1c");
    // R11 mask
    wr(8'h9C, 32'h0000_0100);
    expect_item(1, 8'h00, 32'h1, "R11 irq on");
    expect_item(0, 8'h9C, 32'h0000_0100, "R11 mask read");
    expect_item(0, 8'h48, 32'h0000_0152, "R11 status untouched");
    wr(8'h9C, 32'h0000_0001);
    expect_item(1, 8'h00, 32'h0, "R11 irq off");
    expect_item(0, 8'h48, 32'h0000_0152, "R11 status untouched 2");
    // R10 set wins over clear
    set_ext(32'h0000_03A4);
    idle(4);
    expect_item(0, 8'h48, 32'h0000_0152, "R10 prep no fall on bit1");
    set_ext(32'h0000_03A6);
    idle(1);
    wr(8'h48, 32'h0000_0002);
    expect_item(0, 8'h48, 32'h0000_0152, "R10 edge beats clear");
    wr(8'h48, 32'h0000_0002);
    expect_item(0, 8'h48, 32'h0000_0150, "R10 later clear works");
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule